// File: doc/BRIEF.md
# Minimum Pulse Width Qualifier

This block separates valid pulses from glitches on a single asynchronous level input by measuring how long each high pulse lasts in clock cycles. After the input passes through a synchronizer, every high run is timed against a programmable threshold `T`. Runs that never outlast `T` are dropped completely. A run that does outlast `T` is passed on with its leading edge held back by `T` cycles, and it ends in the same cycle it would have ended with no filtering. The passed pulse is therefore exactly `T` cycles shorter than the synchronized input pulse.

A separate one-cycle strobe reports each input pulse that has outlasted the threshold. The strobe fires in the cycle the filtered output rises. This lets a consumer count qualified events without looking for edges on the filtered level. The threshold is sampled once per pulse, at its synchronized rising edge, so software may rewrite it at any time without corrupting a pulse that is already being timed.

All latencies below count rising clock edges. The raw level sampled at edge `k` is the level captured at edge `k`. With `T = 0`, that level appears on the outputs just after edge `k+2`.

Top module: `pulse_width_qualifier`

## Requirements
- R1: The input passes through two synchronizer flops and one output register. With T = 0, `qual_out` just after edge k+2 equals the `sig_in` level sampled at edge k.
- R2: A synchronized high pulse of W cycles with W <= T produces no `qual_out` cycle and no `wide_stb` cycle.
- R3: For a pulse with W > T, `qual_out` rises exactly T cycles later than it would with T = 0.
- R4: For a pulse with W > T, `qual_out` stays high for exactly W - T cycles and falls in the same cycle it would fall with T = 0.
- R5: `wide_stb` is one cycle wide, is asserted exactly once for each pulse with W > T, and is asserted in the cycle `qual_out` rises.
- R6: With T = 0, `qual_out` reproduces the synchronized input, and every pulse, including a one-cycle pulse, produces one strobe.
- R7: The width counter saturates, so a pulse far longer than 2^CNT_W cycles keeps `qual_out` high until the input falls and produces no second strobe.
- R8: The threshold is captured at the synchronized rising edge of each pulse. A change to `thr` while a pulse is being timed has no effect on that pulse.
- R9: While `rst` is high, and in the cycle after it is asserted, `qual_out` and `wide_stb` are 0, and a pulse in progress is abandoned.
- R10: Two pulses separated by a single low cycle are timed independently, each from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous level to be qualified |
| thr | input | CNT_W | Minimum-width threshold T in cycles, captured per pulse |
| qual_out | output | 1 | Filtered level: delayed by T, shortened by T |
| wide_stb | output | 1 | One-cycle strobe for each pulse longer than T |

## Verification
The bench drives pulses whose width is exactly T, and one cycle on either side of it. An off-by-one in the compare would either pass a pulse of width T as a one-cycle stub or swallow a pulse of width T+1. It runs a pulse of several hundred cycles against an 8-bit counter, where a wrapping counter would drop the output mid-pulse and fire a second strobe. It also rewrites the threshold inside a pulse, where a design that reads the live value would move the leading edge. Back-to-back pulses with a single low cycle between them expose a counter that fails to restart, and T = 0 exposes a design that adds delay or misses one-cycle pulses.

// File: rtl/pwq_pkg.sv
`timescale 1ns/1ps
package pwq_pkg;

    // Where the current synchronized level sits relative to the threshold
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // input low
        PH_ARM  = 2'd1,   // input high, run not yet longer than T
        PH_PASS = 2'd2    // input high, run has outlasted T
    } phase_e;

    // Per-cycle qualification result handed to the output stage
    typedef struct packed {
        logic pass;   // filtered level for this cycle
        logic hit;    // first cycle in which the run exceeds T
    } qual_flags_t;

    localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/pwq_sync.sv
`timescale 1ns/1ps
module pwq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pwq_run_tracker.sv
`timescale 1ns/1ps
module pwq_run_tracker
    import pwq_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s_lvl,
    input  logic [CNT_W-1:0] thr,
    output qual_flags_t      flags
);
    localparam int unsigned RUN_W = CNT_W + 1;

    logic [RUN_W-1:0] run_q, run_d, lim, lim_p1;
    logic [CNT_W-1:0] thr_lat_q, thr_eff;
    logic             rise;
    phase_e           ph;

    always_comb begin
        // run_q holds the run length of the previous cycle: zero means the level was low
        rise    = s_lvl && (run_q == '0);
        thr_eff = rise ? thr : thr_lat_q;
        lim     = {1'b0, thr_eff};
        lim_p1  = lim + RUN_W'(1);

        if (!s_lvl)                run_d = '0;
        else if (run_q >= lim_p1)  run_d = lim_p1;           // saturate one past T
        else                       run_d = run_q + RUN_W'(1);

        if (!s_lvl)                ph = PH_IDLE;
        else if (run_d == lim_p1)  ph = PH_PASS;
        else                       ph = PH_ARM;

        flags.pass = (ph == PH_PASS);
        flags.hit  = (ph == PH_PASS) && (run_q == lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= '0;
            thr_lat_q <= '0;
        end else begin
            run_q <= run_d;
            if (rise) thr_lat_q <= thr;
        end
    end
endmodule

// File: rtl/pwq_out_stage.sv
`timescale 1ns/1ps
module pwq_out_stage
    import pwq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  qual_flags_t flags,
    output logic        level_q,
    output logic        stb_q
);
    qual_flags_t reg_q;

    always_ff @(posedge clk) begin
        if (rst) reg_q <= '0;
        else     reg_q <= flags;
    end

    assign level_q = reg_q.pass;
    assign stb_q   = reg_q.hit;
endmodule

// File: rtl/pulse_width_qualifier.sv
`timescale 1ns/1ps
module pulse_width_qualifier
    import pwq_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SYNC_STAGES = MIN_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_in,
    input  logic [CNT_W-1:0] thr,
    output logic             qual_out,
    output logic             wide_stb
);
    logic        s_sync;
    qual_flags_t flags;

    pwq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (sig_in),
        .q_sync  (s_sync)
    );

    pwq_run_tracker #(.CNT_W(CNT_W)) u_track (
        .clk   (clk),
        .rst   (rst),
        .s_lvl (s_sync),
        .thr   (thr),
        .flags (flags)
    );

    pwq_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags),
        .level_q (qual_out),
        .stb_q   (wide_stb)
    );
endmodule

// File: rtl/pwq_checker.sv
`timescale 1ns/1ps
module pwq_checker (
    input logic clk,
    input logic rst,
    input logic s_sync,
    input logic qual_out,
    input logic wide_stb
);
    // R9: reset clears both outputs on the next edge
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!qual_out && !wide_stb));

    // R5: strobe lasts a single cycle
    assert_stb_single_R5: assert property (@(posedge clk) disable iff (rst)
        wide_stb |=> !wide_stb);

    // R5: strobe coincides with a rising filtered level
    assert_stb_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
        wide_stb |-> (qual_out && !$past(qual_out)));

    // R3: output can only rise together with the strobe
    assert_rise_has_stb_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(qual_out) |-> wide_stb);

    // R4: output falls in the cycle after the synchronized input falls
    assert_fall_follows_R4: assert property (@(posedge clk) disable iff (rst)
        qual_out |-> $past(s_sync));

    // R7: once passing, output holds while the synchronized input stays high
    assert_hold_while_high_R7: assert property (@(posedge clk) disable iff (rst)
        (qual_out && s_sync) |=> qual_out);
endmodule

bind pulse_width_qualifier pwq_checker u_pwq_checker (
    .clk      (clk),
    .rst      (rst),
    .s_sync   (s_sync),
    .qual_out (qual_out),
    .wide_stb (wide_stb)
);

// File: tb/tb_pulse_width_qualifier.sv
`timescale 1ns/1ps
module tb_pulse_width_qualifier;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sig_in = 1'b0;
    logic [CNT_W-1:0] thr = '0;
    logic             qual_out, wide_stb;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    string cur_req = "R9";

    // 50 MHz
    always #10 clk = ~clk;

    pulse_width_qualifier #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .sig_in(sig_in), .thr(thr),
        .qual_out(qual_out), .wide_stb(wide_stb)
    );

    // Behavioural reference: two-deep delay of the raw level, unbounded run length
    int m1, m2, run_len, t_cap;
    bit exp_out, exp_stb;
    always @(posedge clk) begin
        if (rst) begin
            m1 = 0; m2 = 0; run_len = 0; t_cap = 0;
            exp_out = 0; exp_stb = 0;
        end else begin
            if (m2 != 0) begin
                if (run_len == 0) t_cap = int'(thr);
                run_len = run_len + 1;
            end else begin
                run_len = 0;
            end
            exp_out = (m2 != 0) && (run_len > t_cap);
            exp_stb = (m2 != 0) && (run_len == t_cap + 1);
            m2 = m1;
            m1 = int'(sig_in);
        end
    end

    // Running tallies of output activity, and per-cycle compare against the model
    int out_hi = 0;
    int stb_cnt = 0;
    always @(negedge clk) begin
        if (qual_out) out_hi++;
        if (wide_stb) stb_cnt++;
        if (!done) begin
            n_chk++;
            if (qual_out !== exp_out || wide_stb !== exp_stb) begin
                n_bad++;
                $display("FAIL %s cycle %0d: out=%0b stb=%0b expected out=%0b stb=%0b",
                         cur_req, cyc, qual_out, wide_stb, exp_out, exp_stb);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic check(input string req, input int act, input int expv, input string what);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // One pulse of w cycles, then gap low cycles; checks per-pulse tallies
    task automatic pulse(input int w, input int gap, input string req);
        int a0, b0, t;
        t = int'(thr);
        #1; a0 = out_hi; b0 = stb_cnt;
        @(negedge clk); sig_in = 1'b1;
        repeat (w) @(negedge clk);
        sig_in = 1'b0;
        repeat (gap) @(negedge clk);
        #1;
        check(req, out_hi - a0, (w > t) ? (w - t) : 0, "output high cycles");
        check(req, stb_cnt - b0, (w > t) ? 1 : 0, "strobe count");
    endtask

    int seed = 12345;
    function automatic int nxt(input int m);
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 8) & 32'h7fff) % m;
    endfunction

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        #1;
        check("R9", int'(qual_out), 0, "qual_out in reset");
        check("R9", int'(wide_stb), 0, "wide_stb in reset");
        @(negedge clk); rst = 1'b0;

        // R1: latency with T = 0
        cur_req = "R1";
        thr = 0;
        repeat (3) @(negedge clk);
        sig_in = 1'b1;                 // sampled at the next edge (edge k)
        @(negedge clk); @(negedge clk); #1;
        check("R1", int'(qual_out), 0, "output before edge k+2");
        @(negedge clk); #1;
        check("R1", int'(qual_out), 1, "output after edge k+2");
        @(negedge clk); sig_in = 1'b0;
        repeat (5) @(negedge clk);

        // R6: transparent with T = 0, including single-cycle pulses
        cur_req = "R6";
        pulse(1, 5, "R6");
        pulse(2, 5, "R6");
        pulse(7, 5, "R6");

        // R2 / R3 / R4 / R5 around the threshold
        thr = 4;
        cur_req = "R2";
        pulse(1, 6, "R2");
        pulse(3, 6, "R2");
        pulse(4, 6, "R2");
        cur_req = "R3";
        pulse(5, 6, "R3");
        cur_req = "R4";
        pulse(6, 6, "R4");
        pulse(12, 6, "R4");
        cur_req = "R5";
        pulse(20, 6, "R5");

        // R10: one low cycle between pulses
        cur_req = "R10";
        thr = 2;
        begin
            int a0, b0;
            #1; a0 = out_hi; b0 = stb_cnt;
            @(negedge clk); sig_in = 1'b1;
            repeat (5) @(negedge clk); sig_in = 1'b0;
            @(negedge clk); sig_in = 1'b1;
            repeat (4) @(negedge clk); sig_in = 1'b0;
            repeat (6) @(negedge clk); #1;
            check("R10", out_hi - a0, 3 + 2, "output cycles for two close pulses");
            check("R10", stb_cnt - b0, 2, "strobes for two close pulses");
        end

        // R7: saturation with a pulse far longer than 2^CNT_W
        cur_req = "R7";
        thr = 10;
        pulse(600, 6, "R7");
        thr = 255;
        pulse(256, 6, "R7");
        pulse(255, 6, "R7");

        // R8: rewrite threshold mid-pulse
        cur_req = "R8";
        thr = 3;
        begin
            int a0, b0;
            #1; a0 = out_hi; b0 = stb_cnt;
            @(negedge clk); sig_in = 1'b1;
            repeat (4) @(negedge clk);
            thr = 20;
            repeat (6) @(negedge clk); sig_in = 1'b0;
            repeat (6) @(negedge clk); #1;
            check("R8", out_hi - a0, 10 - 3, "output cycles after mid-pulse rewrite");
            check("R8", stb_cnt - b0, 1, "strobe after mid-pulse rewrite");
        end

        // Mixed traffic: random widths, gaps and threshold rewrites, compared each cycle
        cur_req = "R2 R3 R4 R5 R8";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (nxt(5) == 0) thr = CNT_W'(nxt(8));
            sig_in = 1'b1;
            repeat (1 + nxt(12)) @(negedge clk);
            sig_in = 1'b0;
            repeat (1 + nxt(6)) @(negedge clk);
        end
        repeat (6) @(negedge clk);

        // R9: reset in the middle of a qualified pulse
        cur_req = "R9";
        thr = 1;
        sig_in = 1'b1;
        repeat (6) @(negedge clk);
        #1;
        check("R9", int'(qual_out), 1, "output passing before reset");
        rst = 1'b1;
        @(negedge clk); #1;
        check("R9", int'(qual_out), 0, "qual_out after reset edge");
        check("R9", int'(wide_stb), 0, "wide_stb after reset edge");
        sig_in = 1'b0;
        @(negedge clk); rst = 1'b0;
        repeat (4) @(negedge clk);

        finish_run();
    end
endmodule